// File: doc/BRIEF.md
# PHY Register Access Handshake Master

This block gives a host a plain read/write port onto PHY configuration registers that are not mapped into the bus address space. The host presents a 16-bit register address and, for a write, 16 bits of data, then pulses `req`. The block turns that request into a series of four-phase handshakes on a 20-bit control word and a 17-bit status word. In each handshake it raises one strobe, waits for the acknowledge to go high, drops the strobe, and waits for the acknowledge to go low.

Every access starts by capturing the address. A write then captures the data and fires a write strobe. A read fires a read strobe and takes the returned data while the acknowledge is high. Each acknowledge wait samples the status word a bounded number of times, `POLL_GAP` cycles apart. If the acknowledge never reaches the level the block is waiting for, the access is abandoned and reported as a timeout. The result is reported by a single-cycle `done` pulse, and `timeout` is high in that same cycle when the access failed.

Top module: `phy_reg_hs_master`

## Requirements
- R1: The control word `phy_ctrl` carries the address or data in bits 15:0 and four strobes: bit 16 captures the address, bit 17 captures the data, bit 18 writes and bit 19 reads.
- R2: In the status word `phy_stat`, bit 16 is the acknowledge and bits 15:0 are the returned register data.
- R3: Each access starts by driving the address alone for one cycle. The block then adds the address-capture strobe, waits for the acknowledge to go high, drives the address alone again and waits for the acknowledge to go low.
- R4: A write then drives the data alone for one cycle and adds the data-capture strobe, with the same high wait, drop and low wait. Next it raises only the write strobe, waits for high, returns to the data alone and waits for low. The write ends with the control word at zero.
- R5: A read raises only the read strobe and waits for the acknowledge to go high. It places bits 15:0 of the status word on `rdata`, clears the control word to zero and waits for the acknowledge to go low.
- R6: At most one strobe is high at any time. A raised strobe keeps its control word unchanged until the acknowledge is high or the wait times out.
- R7: A wait checks the acknowledge in its first cycle and then every `POLL_GAP` cycles, `POLL_MAX` checks in all. If the acknowledge never rises, `done` is high in the cycle that follows the 2+(`POLL_MAX`-1)*`POLL_GAP`-th clock edge after the edge that accepts `req`. An acknowledge that arrives before the last check still lets the access succeed.
- R8: A timeout stops the sequence, clears the control word to zero and raises `timeout` in the same cycle as `done`. `timeout` is never high without `done`.
- R9: `done` is high for exactly one cycle per accepted request, and the control word is zero whenever `done` is high.
- R10: A `req` that arrives from acceptance until `done` has no effect. It causes no extra `done`, no register write and no change to the access in progress.
- R11: While `rst_n` is low (synchronous, active low), `phy_ctrl`, `rdata`, `done` and `timeout` are zero after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start an access (taken only when idle) |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | PHY register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Access abandoned (only with `done`) |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
The assertions assume the PHY side moves its acknowledge only in response to the strobes. They also assume `req` is a level sampled on the clock and does not need to drop for the block to behave correctly. The bench's responder model follows the four-phase rule. Its response latency is random but bounded, and most draws fall well inside the poll window. Directed cases pin the acknowledge low or high to force timeouts in the high wait and in the low wait, and one delayed-acknowledge case lands just before the final check.

// File: rtl/phyhs_pkg.sv
// Package phyhs_pkg
// Shared types and field positions of the PHY handshake master.
// Assumes a 16-bit PHY register space and a 20-bit control word.
package phyhs_pkg;
    localparam int DW        = 16;
    localparam int CTRL_W    = DW + 4;
    localparam int STAT_W    = DW + 1;
    localparam int B_CAPADR  = DW;
    localparam int B_CAPDAT  = DW + 1;
    localparam int B_WRITE   = DW + 2;
    localparam int B_READ    = DW + 3;
    localparam int B_ACK     = DW;

    typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_WR, PH_RD} phase_t;
    typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_WHI, ST_WLO, ST_FIN} state_t;
endpackage

// File: rtl/phyhs_poll_timer.sv
// Module phyhs_poll_timer
// Paces acknowledge checks during one wait. The check strobe goes high in the
// first cycle (when restart is high) and then every POLL_GAP cycles while
// active. The last flag marks the POLL_MAX-th check.
// Assumes restart is high exactly in the first cycle of each wait.
module phyhs_poll_timer #(
    parameter int POLL_MAX = 10,
    parameter int POLL_GAP = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    output logic chk,
    output logic chk_last
);
    localparam int CW = $clog2(POLL_MAX + 1);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam logic [GW-1:0] GAP_RELOAD = GW'(POLL_GAP - 1);
    localparam logic [CW-1:0] CNT_LAST   = CW'(POLL_MAX - 1);

    logic [GW-1:0] gap_q, gap_eff;
    logic [CW-1:0] cnt_q, cnt_eff;

    // Effective counters: a restart behaves like a fresh wait
    always_comb begin
        gap_eff  = restart ? '0 : gap_q;
        cnt_eff  = restart ? '0 : cnt_q;
        chk      = active && (gap_eff == '0);
        chk_last = (cnt_eff == CNT_LAST);
    end

    // Advance the gap and check counters while a wait is running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            cnt_q <= '0;
        end else if (active) begin
            if (gap_eff == '0) begin
                gap_q <= GAP_RELOAD;
                cnt_q <= cnt_eff + 1'b1;
            end else begin
                gap_q <= gap_eff - 1'b1;
                cnt_q <= cnt_eff;
            end
        end
    end
endmodule

// File: rtl/phyhs_seq.sv
// Module phyhs_seq
// Step sequencer: address phase, then data and write phases or a read
// phase, each as a four-phase handshake on the control word.
// Assumes chk/chk_last come from phyhs_poll_timer driven by fresh/polling.
module phyhs_seq
    import phyhs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [DW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [STAT_W-1:0] stat,
    input  logic              chk,
    input  logic              chk_last,
    output logic              polling,
    output logic              fresh,
    output logic [CTRL_W-1:0] ctrl,
    output logic [DW-1:0]     rdata,
    output logic              done,
    output logic              timeout
);
    state_t        st;
    phase_t        ph;
    logic [DW-1:0] a_q, d_q;
    logic          we_q, to_q;
    logic          ack;

    // Control word with the strobe of a phase raised
    function automatic logic [CTRL_W-1:0] strobe_word(phase_t p, logic [DW-1:0] a, logic [DW-1:0] d);
        case (p)
            PH_ADDR: strobe_word = {4'b0001, a};
            PH_DATA: strobe_word = {4'b0010, d};
            PH_WR:   strobe_word = {4'b0100, {DW{1'b0}}};
            default: strobe_word = {4'b1000, {DW{1'b0}}};
        endcase
    endfunction

    // Control word after the strobe of a phase is dropped
    function automatic logic [CTRL_W-1:0] drop_word(phase_t p, logic [DW-1:0] a, logic [DW-1:0] d);
        case (p)
            PH_ADDR: drop_word = {4'b0000, a};
            PH_DATA: drop_word = {4'b0000, d};
            PH_WR:   drop_word = {4'b0000, d};
            default: drop_word = '0;
        endcase
    endfunction

    // Decode status and outputs
    always_comb begin
        ack     = stat[B_ACK];
        polling = (st == ST_WHI) || (st == ST_WLO);
        done    = (st == ST_FIN);
        timeout = (st == ST_FIN) && to_q;
    end

    // Step through the handshake phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            ph    <= PH_ADDR;
            a_q   <= '0;
            d_q   <= '0;
            we_q  <= 1'b0;
            to_q  <= 1'b0;
            fresh <= 1'b0;
            ctrl  <= '0;
            rdata <= '0;
        end else begin
            fresh <= 1'b0;
            case (st)
                ST_IDLE: if (req) begin
                    a_q  <= addr;
                    d_q  <= wdata;
                    we_q <= we;
                    to_q <= 1'b0;
                    ph   <= PH_ADDR;
                    ctrl <= {4'b0000, addr};
                    st   <= ST_PRE;
                end
                ST_PRE: begin
                    ctrl  <= strobe_word(ph, a_q, d_q);
                    fresh <= 1'b1;
                    st    <= ST_WHI;
                end
                ST_WHI: if (chk) begin
                    if (ack) begin
                        if (ph == PH_RD) rdata <= stat[DW-1:0];
                        ctrl  <= drop_word(ph, a_q, d_q);
                        fresh <= 1'b1;
                        st    <= ST_WLO;
                    end else if (chk_last) begin
                        ctrl <= '0;
                        to_q <= 1'b1;
                        st   <= ST_FIN;
                    end
                end
                ST_WLO: if (chk) begin
                    if (!ack) begin
                        case (ph)
                            PH_ADDR: if (we_q) begin
                                ph   <= PH_DATA;
                                ctrl <= {4'b0000, d_q};
                                st   <= ST_PRE;
                            end else begin
                                ph    <= PH_RD;
                                ctrl  <= strobe_word(PH_RD, a_q, d_q);
                                fresh <= 1'b1;
                                st    <= ST_WHI;
                            end
                            PH_DATA: begin
                                ph    <= PH_WR;
                                ctrl  <= strobe_word(PH_WR, a_q, d_q);
                                fresh <= 1'b1;
                                st    <= ST_WHI;
                            end
                            default: begin
                                ctrl <= '0;
                                st   <= ST_FIN;
                            end
                        endcase
                    end else if (chk_last) begin
                        ctrl <= '0;
                        to_q <= 1'b1;
                        st   <= ST_FIN;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phy_reg_hs_master.sv
// Module phy_reg_hs_master
// Top: a host read/write port turned into strobe/acknowledge handshakes on a
// PHY control and status word pair. POLL_GAP is the spacing of acknowledge
// checks in clock cycles, POLL_MAX the number of checks per wait.
// Assumes the PHY acknowledge moves only in answer to a strobe.
module phy_reg_hs_master
    import phyhs_pkg::*;
#(
    parameter int POLL_MAX = 10,
    parameter int POLL_GAP = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [DW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              done,
    output logic              timeout,
    output logic [CTRL_W-1:0] phy_ctrl,
    input  logic [STAT_W-1:0] phy_stat
);
    logic chk, chk_last, polling, fresh;

    phyhs_poll_timer #(.POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)) u_timer (
        .clk(clk), .rst_n(rst_n), .active(polling), .restart(fresh),
        .chk(chk), .chk_last(chk_last)
    );

    phyhs_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .stat(phy_stat), .chk(chk), .chk_last(chk_last),
        .polling(polling), .fresh(fresh), .ctrl(phy_ctrl), .rdata(rdata),
        .done(done), .timeout(timeout)
    );
endmodule

// File: rtl/phyhs_checker.sv
// Module phyhs_checker
// Protocol properties of phy_reg_hs_master, attached by bind.
module phyhs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        timeout,
    input logic [19:0] phy_ctrl,
    input logic [16:0] phy_stat
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctrl[19:16])); // R6
    AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((phy_ctrl[19:16] != 4'b0) && !phy_stat[16]) |=> ($stable(phy_ctrl) || timeout)); // R6
    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_CTRL_ZERO_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phy_ctrl == 20'h0)); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!done && phy_ctrl == 20'h0)); // R11
endmodule

bind phy_reg_hs_master phyhs_checker u_phyhs_checker (
    .clk(clk), .rst_n(rst_n), .done(done), .timeout(timeout),
    .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
);

// File: tb/tb_phy_reg_hs_master.sv
module tb_phy_reg_hs_master;
    localparam int PMAX = 10;
    localparam int PGAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic [15:0] rdata;
    logic        done, timeout;
    logic [19:0] phy_ctrl;
    logic [16:0] phy_stat;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    phy_reg_hs_master #(.POLL_MAX(PMAX), .POLL_GAP(PGAP)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .done(done), .timeout(timeout),
        .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
    );

    // Responder model: mode 0 normal, 1 ack stuck low, 2 ack stuck high
    int          mode = 0;
    int          lat = 0;
    int          lcnt;
    logic        ack;
    logic [3:0]  prev_s;
    logic [15:0] cap_a, cap_d, wr_a, wr_d;
    int          wr_cnt;
    logic [15:0] mem [16];
    logic [15:0] shadow [16];

    assign phy_stat = {ack, mem[cap_a[3:0]]};

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0; lcnt <= 0; prev_s <= '0; cap_a <= '0; cap_d <= '0;
            wr_a <= '0; wr_d <= '0; wr_cnt <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else begin
            prev_s <= phy_ctrl[19:16];
            if (phy_ctrl[16] && !prev_s[0]) cap_a <= phy_ctrl[15:0];
            if (phy_ctrl[17] && !prev_s[1]) cap_d <= phy_ctrl[15:0];
            if (phy_ctrl[18] && !prev_s[2]) begin
                mem[cap_a[3:0]] <= cap_d; wr_a <= cap_a; wr_d <= cap_d; wr_cnt <= wr_cnt + 1;
            end
            if (mode == 1) ack <= 1'b0;
            else if (mode == 2) ack <= 1'b1;
            else if (ack != (|phy_ctrl[19:16])) begin
                if (lcnt >= lat) begin ack <= |phy_ctrl[19:16]; lcnt <= 0; end
                else lcnt <= lcnt + 1;
            end else lcnt <= 0;
        end
    end

    task automatic check(input bit ok, input string req_id, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req_id, act, exp);
        end
    endtask

    int last_cyc, last_dones;
    logic last_to;

    // Issue one access; optionally fire a second req while busy
    task automatic run_op(input logic w, input logic [15:0] a, input logic [15:0] d, input bit poke);
        int cyc = 0;
        int dones = 0;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; cyc = 1;
        last_to = 1'b0;
        while (!done && cyc < 2000) begin
            if (poke && cyc == 5) begin req = 1'b1; we = 1'b1; addr = a ^ 16'h0005; wdata = ~d; end
            else req = 1'b0;
            @(negedge clk); cyc++;
        end
        req = 1'b0;
        last_cyc = cyc;
        if (done) begin dones = 1; last_to = timeout; end
        check(phy_ctrl == 20'h0, "R9 ctrl zero at done", phy_ctrl, 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done) dones++;
        end
        last_dones = dones;
        check(dones == 1, poke ? "R10 single done" : "R9 single done", dones, 1);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        int wc = wr_cnt;
        run_op(1'b1, a, d, 1'b0);
        shadow[a[3:0]] = d;
        check(!last_to, "R4 write no timeout", last_to, 0);
        check(cap_a == a, "R3 captured address", cap_a, a);
        check(wr_a == a && wr_d == d, "R4 written data", {wr_a, wr_d}, {a, d});
        check(wr_cnt == wc + 1, "R4 one write strobe", wr_cnt, wc + 1);
    endtask

    task automatic do_read(input logic [15:0] a, input bit poke);
        int wc = wr_cnt;
        run_op(1'b0, a, 16'h0, poke);
        check(!last_to, "R7 read no timeout", last_to, 0);
        check(cap_a == a, "R3 captured address", cap_a, a);
        check(rdata == shadow[a[3:0]], "R5 read data", rdata, shadow[a[3:0]]);
        if (poke) check(wr_cnt == wc, "R10 no write from ignored req", wr_cnt, wc);
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] a, d;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        check(phy_ctrl == 20'h0, "R11 ctrl reset", phy_ctrl, 0);
        check(!done && !timeout, "R11 flags reset", {done, timeout}, 0);
        check(rdata == 16'h0, "R11 rdata reset", rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // Directed: R1/R2 field use via write then read of one register
        do_write(16'h0003, 16'hA5C3);
        do_read(16'h0003, 1'b0);
        // Random mix
        for (int n = 0; n < 40; n++) begin
            lat = $urandom_range(0, 6);
            a = 16'($urandom_range(0, 65535));
            d = 16'($urandom_range(0, 65535));
            if ($urandom_range(0, 1) == 1) do_write(a, d);
            else do_read(a, 1'b0);
        end
        // R7: late acknowledge, just before the last check
        lat = 30;
        do_write(16'h0009, 16'h1234);
        do_read(16'h0009, 1'b0);
        lat = 1;
        // R10: request while busy is ignored
        do_read(16'h0009, 1'b1);
        do_read(16'h000C, 1'b0);
        // R7/R8: acknowledge never rises
        mode = 1;
        run_op(1'b1, 16'h0001, 16'hFFFF, 1'b0);
        check(last_to == 1'b1, "R8 timeout with done", last_to, 1);
        check(last_cyc == 3 + (PMAX - 1) * PGAP, "R7 timeout latency", last_cyc, 3 + (PMAX - 1) * PGAP);
        // R8: acknowledge stuck high, times out in the low wait
        mode = 2;
        repeat (2) @(negedge clk);
        run_op(1'b0, 16'h0002, 16'h0, 1'b0);
        check(last_to == 1'b1, "R8 timeout in low wait", last_to, 1);
        check(last_cyc == 4 + (PMAX - 1) * PGAP, "R7 low wait latency", last_cyc, 4 + (PMAX - 1) * PGAP);
        check(!timeout, "R8 timeout only with done", timeout, 0);
        mode = 0;
        repeat (10) @(negedge clk);
        do_read(16'h0003, 1'b0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule